// File: doc/BRIEF.md
# Image Sensor Line Capture Controller

This block sits between a CMOS image sensor and a dual-port line buffer, and it runs on the sensor's pixel clock. A host in its own clock domain raises a capture-enable request. The block waits for a fresh frame to start, then for a fresh line to start. It then writes every pixel of that line into the sensor-side port of the buffer, one word per pixel clock, at consecutive addresses from zero. When the line ends, the block raises a done flag toward the host. The flag stays up, and no further pixels are stored, until the host drops its request.

The block has two-flop synchronizers for each control signal that crosses between domains. The enable request and the reset pass into the pixel domain. The done flag passes back into the host domain. The buffer memory, host bus decoding and sensor setup are outside the block. The buffer has 1024 words of 8 bits by default. A line longer than the buffer fills it, the remaining pixels of that line are dropped, and an overflow flag is raised.

Top module: `sensor_line_capture`

## Requirements
- R1: The k-th pixel stored in a capture (k counted from 0) is written at address k, and its data is the pixel bus value sampled on the same pixel clock edge that decided to store it.
- R2: `wr_en_o` is high for exactly one pixel clock per stored pixel. A pixel sampled at edge N shows up on the write port in the cycle after edge N, and the write port is never active while the controller is idle or done.
- R3: The first falling edge of line-valid after capture began ends the capture and raises `capture_done_o` in the host domain. While enable stays high, `capture_done_o` stays high and later frames and lines store nothing.
- R4: After the host drops enable, `capture_done_o` falls and the controller goes idle. A later enable produces a new capture that again starts at address 0.
- R5: If frame-valid and line-valid are already high when enable arrives, nothing from that frame is stored. Capture begins only after a rising frame-valid followed by a rising line-valid.
- R6: If frame-valid and line-valid rise on the same pixel clock, capture starts with the pixel on that clock.
- R7: Addresses saturate at DEPTH-1. Pixels of the line beyond DEPTH are dropped and set `overflow_o`. A line of exactly DEPTH pixels leaves `overflow_o` low. A new enable clears `overflow_o`.
- R8: While `rst_ni` is low, `wr_en_o`, `wr_addr_o`, `overflow_o` and `capture_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Sensor pixel clock |
| host_clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronized into each domain on release |
| capture_en_i | input | 1 | Capture request, host domain |
| frame_valid_i | input | 1 | Sensor frame-valid |
| line_valid_i | input | 1 | Sensor line-valid |
| pix_data_i | input | DATA_W (8) | Sensor pixel bus |
| wr_addr_o | output | ADDR_W (10) | Buffer write address, pixel domain |
| wr_en_o | output | 1 | Buffer write enable, pixel domain |
| wr_data_o | output | DATA_W (8) | Buffer write data, pixel domain |
| overflow_o | output | 1 | Line exceeded buffer depth, pixel domain |
| capture_done_o | output | 1 | Capture complete, host domain |

## Verification
The bench builds the block with DEPTH set to 16, so the address width is 4. With a buffer this small, line lengths on both sides of the limit take only a few cycles. The bench sweeps lengths from 1 to 20, covering a single pixel, one below the limit, the exact limit and lines that overflow. For each sweep it checks every write address and data word against a tagged pattern that identifies frame and line. It also covers two start cases: arming while a line is already in progress, and frame-valid and line-valid rising together.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FRAME,
    ST_WAIT_LINE,
    ST_CAPTURE,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/slc_sync.sv
module slc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slc_ctrl.sv
module slc_ctrl
  import slc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fv_i,
  input  logic              lv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              overflow_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  cap_state_e        state_q, state_d;
  logic              fv_q, lv_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              full_q, ovf_q, we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  logic fv_rise, lv_rise, lv_fall, start, take, arm;

  assign fv_rise = fv_i & ~fv_q;
  assign lv_rise = lv_i & ~lv_q;
  assign lv_fall = lv_q & ~lv_i;

  // line start: fresh line inside a frame, or frame and line rising together
  assign start = en_i &
                 (((state_q == ST_WAIT_LINE) & fv_i & lv_rise) |
                  ((state_q == ST_WAIT_FRAME) & fv_rise & lv_rise));
  assign take  = start | (en_i & (state_q == ST_CAPTURE) & fv_i & lv_i);
  assign arm   = (state_q == ST_IDLE) & en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (en_i) state_d = ST_WAIT_FRAME;
      ST_WAIT_FRAME: begin
        if (!en_i)                    state_d = ST_IDLE;
        else if (fv_rise && lv_rise)  state_d = ST_CAPTURE;
        else if (fv_rise)             state_d = ST_WAIT_LINE;
      end
      ST_WAIT_LINE: begin
        if (!en_i)        state_d = ST_IDLE;
        else if (!fv_i)   state_d = ST_WAIT_FRAME;
        else if (lv_rise) state_d = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        if (!en_i)        state_d = ST_IDLE;
        else if (lv_fall) state_d = ST_DONE;
      end
      ST_DONE:       if (!en_i) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fv_q    <= 1'b0;
      lv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fv_q    <= fv_i;
      lv_q    <= lv_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= take & ~full_q;
      if (arm) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else if (take) begin
        if (full_q) begin
          ovf_q <= 1'b1;
        end else begin
          waddr_q <= cnt_q;
          wdata_q <= data_i;
          if (cnt_q == LAST_ADDR) full_q <= 1'b1;
          else                    cnt_q  <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign wr_addr_o  = waddr_q;
  assign wr_en_o    = we_q;
  assign wr_data_o  = wdata_q;
  assign overflow_o = ovf_q;
  assign done_o     = (state_q == ST_DONE);

  p_addr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> wr_addr_o == $past(wr_addr_o) + 1'b1);

  p_no_write_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_DONE) |=> !wr_en_o);

  p_hold_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && en_i) |=> done_o);

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !en_i) |=> (state_q == ST_IDLE));

  p_no_write_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && $past(full_q)) |-> !wr_en_o);
endmodule

// File: rtl/sensor_line_capture.sv
module sensor_line_capture #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              pix_clk_i,
  input  logic              host_clk_i,
  input  logic              rst_ni,
  input  logic              capture_en_i,
  input  logic              frame_valid_i,
  input  logic              line_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              overflow_o,
  output logic              capture_done_o
);
  logic pix_rst_n, host_rst_n, en_pix, done_pix;

  // reset: asynchronous assert, synchronous release per domain
  slc_sync #(.STAGES(SYNC_STAGES)) i_pix_rst (
    .clk_i(pix_clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(pix_rst_n));

  slc_sync #(.STAGES(SYNC_STAGES)) i_host_rst (
    .clk_i(host_clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(host_rst_n));

  slc_sync #(.STAGES(SYNC_STAGES)) i_en_sync (
    .clk_i(pix_clk_i), .rst_ni(pix_rst_n), .d_i(capture_en_i), .q_o(en_pix));

  slc_sync #(.STAGES(SYNC_STAGES)) i_done_sync (
    .clk_i(host_clk_i), .rst_ni(host_rst_n), .d_i(done_pix), .q_o(capture_done_o));

  slc_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i      (pix_clk_i),
    .rst_ni     (pix_rst_n),
    .en_i       (en_pix),
    .fv_i       (frame_valid_i),
    .lv_i       (line_valid_i),
    .data_i     (pix_data_i),
    .wr_addr_o  (wr_addr_o),
    .wr_en_o    (wr_en_o),
    .wr_data_o  (wr_data_o),
    .overflow_o (overflow_o),
    .done_o     (done_pix)
  );
endmodule

// File: tb/test_sensor_line_capture.sv
module test_sensor_line_capture;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic pix_clk = 1'b0, host_clk = 1'b0, rst_n = 1'b0;
  logic cap_en = 1'b0, fv = 1'b0, lv = 1'b0;
  logic [DATA_W-1:0] pix = '0;
  logic [ADDR_W-1:0] wr_addr;
  logic wr_en, ovf, done;
  logic [DATA_W-1:0] wr_data;

  int checks = 0, errors = 0;
  int wcnt = 0;
  int exp_tag = 0;

  always #2.5 pix_clk = ~pix_clk;
  always #6   host_clk = ~host_clk;

  sensor_line_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_sensor_line_capture (
    .pix_clk_i(pix_clk), .host_clk_i(host_clk), .rst_ni(rst_n),
    .capture_en_i(cap_en), .frame_valid_i(fv), .line_valid_i(lv),
    .pix_data_i(pix), .wr_addr_o(wr_addr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .overflow_o(ovf), .capture_done_o(done));

  function automatic logic [7:0] pat(int tag, int i);
    return {tag[2:0], i[4:0]};
  endfunction

  function automatic int tag_of(int f, int l);
    return (f * 3 + l) & 7;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // write monitor: R1 address and data per stored pixel
  always @(negedge pix_clk) begin
    if (rst_n && wr_en) begin
      chk(int'(wr_addr) == wcnt, "R1", "write address", int'(wr_addr), wcnt);
      chk(wr_data == pat(exp_tag, wcnt), "R1", "write data",
          int'(wr_data), int'(pat(exp_tag, wcnt)));
      wcnt++;
    end
  end

  task automatic pix_wait(int n);
    repeat (n) @(negedge pix_clk);
  endtask

  task automatic set_en(bit v);
    @(negedge host_clk);
    cap_en = v;
    pix_wait(10);
  endtask

  task automatic send_line(int tag, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge pix_clk);
      lv = 1'b1;
      pix = pat(tag, i);
    end
    @(negedge pix_clk);
    lv = 1'b0;
    pix = '0;
    pix_wait(3);
  endtask

  task automatic send_frame(int f, int nlines, int len);
    @(negedge pix_clk);
    fv = 1'b1;
    pix_wait(2);
    for (int l = 0; l < nlines; l++) send_line(tag_of(f, l), len);
    @(negedge pix_clk);
    fv = 1'b0;
    pix_wait(4);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int lens[8] = '{1, 2, 3, 5, 15, 16, 17, 20};
    int f = 0;
    pix_wait(3);
    chk(wr_en == 1'b0, "R8", "wr_en in reset", int'(wr_en), 0);
    chk(wr_addr == '0, "R8", "wr_addr in reset", int'(wr_addr), 0);
    chk(ovf == 1'b0, "R8", "overflow in reset", int'(ovf), 0);
    chk(done == 1'b0, "R8", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    pix_wait(6);

    // sweep of line lengths around the buffer depth
    foreach (lens[k]) begin
      int len = lens[k];
      int exp_w = (len > DEPTH) ? DEPTH : len;
      f = k;
      exp_tag = tag_of(f, 0);
      wcnt = 0;
      set_en(1'b1);
      chk(ovf == 1'b0, "R7", "overflow cleared on arm", int'(ovf), 0);
      send_frame(f, 3, len);
      chk(wcnt == exp_w, "R2", "stored pixel count", wcnt, exp_w);
      chk(ovf == (len > DEPTH), "R7", "overflow flag", int'(ovf), int'(len > DEPTH));
      repeat (4) @(negedge host_clk);
      chk(done == 1'b1, "R3", "done after line", int'(done), 1);
      send_frame(f + 1, 2, len);
      chk(wcnt == exp_w, "R3", "no store while done", wcnt, exp_w);
      chk(done == 1'b1, "R3", "done held", int'(done), 1);
      set_en(1'b0);
      repeat (4) @(negedge host_clk);
      chk(done == 1'b0, "R4", "done cleared", int'(done), 0);
    end

    // arm while a line is already in progress
    wcnt = 0;
    exp_tag = tag_of(21, 0);
    @(negedge pix_clk);
    fv = 1'b1;
    pix_wait(2);
    lv = 1'b1;
    pix = pat(tag_of(20, 0), 0);
    set_en(1'b1);
    pix_wait(5);
    lv = 1'b0;
    pix_wait(3);
    send_line(tag_of(20, 1), 6);
    fv = 1'b0;
    pix_wait(4);
    chk(wcnt == 0, "R5", "no store mid-frame", wcnt, 0);
    send_frame(21, 2, 7);
    chk(wcnt == 7, "R5", "store after fresh frame", wcnt, 7);
    set_en(1'b0);
    repeat (4) @(negedge host_clk);
    chk(done == 1'b0, "R4", "done cleared after mid-frame case", int'(done), 0);

    // frame and line rising on the same clock
    wcnt = 0;
    exp_tag = tag_of(30, 0);
    set_en(1'b1);
    @(negedge pix_clk);
    fv = 1'b1;
    lv = 1'b1;
    pix = pat(exp_tag, 0);
    @(negedge pix_clk);
    chk(wr_en == 1'b1, "R6", "store on joint rise", int'(wr_en), 1);
    chk(wr_data == pat(exp_tag, 0), "R2", "one-cycle latency data",
        int'(wr_data), int'(pat(exp_tag, 0)));
    for (int i = 1; i < 5; i++) begin
      pix = pat(exp_tag, i);
      @(negedge pix_clk);
    end
    lv = 1'b0;
    fv = 1'b0;
    pix_wait(4);
    chk(wcnt == 5, "R6", "joint rise count", wcnt, 5);
    set_en(1'b0);
    repeat (4) @(negedge host_clk);

    finish_run();
  end
endmodule